// File: doc/BRIEF.md
# Three-Stage Noise-Shaping Division Modulator

This block supplies a fractional-N frequency synthesizer with the divide value to use on each reference period. Three first-order accumulators are chained: the first adds the fractional word K to its residue modulo F, and each later stage adds the fresh residue of the stage before it. The wrap carries of the three stages are combined through first and second differences so that the errors of the earlier stages cancel. The resulting offset d moves among −3..+4 on every update. Its long-run mean is K/F, so the mean divide value is N + K/F. The quantization noise is pushed toward high offset frequencies, where the loop filter removes it.

Each pulse on the update strobe advances all accumulators and delay registers by one step and latches the new offset. The output is the integer part N plus the latched offset. Because of this, a new N is seen on the output right away, while the offset only changes on an update.

Top module: `mash_div_modulator`

## Requirements
- R1: Each of the three stages adds its input to its residue; when the sum is at least F it subtracts F and raises a carry of 1, otherwise the carry is 0. Stage 1 takes K. Stages 2 and 3 take the residue that the previous stage produces in the same update.
- R2: For any F ≥ 1 and K ≤ F−1, every residue stays below F, including the corner K = F−1.
- R3: The offset of an update is d = c1 + (c2 − c2') + (c3 − 2·c3' + c3''), where ' and '' mark the carries of the previous update and of the one before it. Carries from before reset count as 0.
- R4: The offset d always lies in −3..+4.
- R5: `div_ratio` equals n_int plus the offset latched by the most recent update, as an unsigned NI_W+1-bit value. A change of n_int shows on the output without an update. With n_int ≥ 4 the ratio is never below 1.
- R6: A clock edge with `step` low changes no residue, carry delay or latched offset.
- R7: A clock edge with `rst_n` low clears all residues, carry delays and the latched offset, so the output equals n_int afterwards.
- R8: The offsets of any F consecutive updates sum to K within ±3. With K = 0, every offset is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step | input | 1 | Update strobe, one pulse per reference period |
| n_int | input | NI_W | Integer part N of the divide value |
| k_frac | input | ACC_W | Fractional numerator K |
| f_mod | input | ACC_W | Fractional modulus F |
| div_ratio | output | NI_W+1 | Divide value for the coming period, N + d |

## Verification
The assertions take for granted that F is at least 1, that K is below F, and that F changes only while reset is held. The residue bound also relies on the accumulators starting from zero under the current modulus. The ratio floor assumes N of at least 4. The stimulus sets every new K, F and N inside a reset pulse, draws F in 2..501 and K below F, and adds directed cases for K = 0, K = F−1, F = 1 and the largest N. After that, only n_int is changed mid-run.

// File: rtl/mash_div_pkg.sv
// Shared constants and types for the noise-shaping division modulator.
// Assumes the combiner is written for exactly three cascaded stages.
package mash_div_pkg;
    localparam int NUM_STAGES = 3;
    localparam int OFS_W      = 4;          // holds -3..+4 signed
    typedef logic signed [OFS_W-1:0] ofs_t;
endpackage

// File: rtl/mash_stage.sv
// One first-order accumulator stage: residue plus input, modulo the modulus.
// Produces the next residue and the wrap carry combinationally and commits
// the residue on the update strobe.
// Assumes add_in < modulus and a modulus that changes only during reset.
module mash_stage #(
    parameter int ACC_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [ACC_W-1:0] add_in,
    input  logic [ACC_W-1:0] modulus,
    output logic [ACC_W-1:0] res_next,
    output logic             wrap
);
    localparam int SUM_W = ACC_W + 1;

    logic [ACC_W-1:0] res_q;
    logic [SUM_W-1:0] sum;

    // Modulo add: subtract the modulus once when the sum reaches it.
    always_comb begin
        sum      = {1'b0, res_q} + {1'b0, add_in};
        wrap     = (sum >= {1'b0, modulus});
        res_next = wrap ? ACC_W'(sum - {1'b0, modulus}) : ACC_W'(sum);
    end

    // Residue register: cleared by reset, advanced only on the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            res_q <= '0;
        else if (step)
            res_q <= res_next;
    end

    // R2: stored residue stays below the modulus
    p_residue_below_mod_r2: assert property (@(posedge clk) disable iff (!rst_n)
        res_q < modulus);
endmodule

// File: rtl/mash_combiner.sv
// Combines the three stage carries into the noise-shaped offset using a
// first difference on carry 2 and a second difference on carry 3.
// Assumes carries are only meaningful on cycles where step is high.
module mash_combiner
    import mash_div_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  step,
    input  logic [NUM_STAGES-1:0] carry,
    output ofs_t                  ofs
);
    logic c2_d;
    logic c3_d1;
    logic c3_d2;

    // Error-cancelling sum of current and delayed carries.
    always_comb begin
        ofs = ofs_t'({3'b000, carry[0]})
            + ofs_t'({3'b000, carry[1]}) - ofs_t'({3'b000, c2_d})
            + ofs_t'({3'b000, carry[2]}) - ofs_t'({2'b00, c3_d1, 1'b0})
            + ofs_t'({3'b000, c3_d2});
    end

    // Carry delay line: one tap for stage 2, two taps for stage 3.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c2_d  <= 1'b0;
            c3_d1 <= 1'b0;
            c3_d2 <= 1'b0;
        end else if (step) begin
            c2_d  <= carry[1];
            c3_d1 <= carry[2];
            c3_d2 <= c3_d1;
        end
    end

    // R4: offset confined to -3..+4
    p_offset_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs >= -4'sd3) && (ofs <= 4'sd4));
endmodule

// File: rtl/mash_div_modulator.sv
// Three-stage cascaded accumulator modulator that produces the per-period
// divide value N + d for a fractional-N divider. The mean of d is K/F.
// Assumes f_mod >= 1, k_frac < f_mod, f_mod changed only during reset,
// and n_int >= 4 so that the ratio stays positive.
module mash_div_modulator
    import mash_div_pkg::*;
#(
    parameter int ACC_W = 12,
    parameter int NI_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [NI_W-1:0]  n_int,
    input  logic [ACC_W-1:0] k_frac,
    input  logic [ACC_W-1:0] f_mod,
    output logic [NI_W:0]    div_ratio
);
    localparam int RAT_W = NI_W + 1;
    localparam int EXT_W = RAT_W - OFS_W;

    logic [ACC_W-1:0]      chain [NUM_STAGES+1];
    logic [NUM_STAGES-1:0] carry;
    ofs_t                  ofs_now;
    ofs_t                  ofs_q;

    assign chain[0] = k_frac;

    // Cascade: each stage integrates the fresh residue of the one before.
    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
        mash_stage #(.ACC_W(ACC_W)) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .step     (step),
            .add_in   (chain[i]),
            .modulus  (f_mod),
            .res_next (chain[i+1]),
            .wrap     (carry[i])
        );
    end

    mash_combiner u_comb (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .carry (carry),
        .ofs   (ofs_now)
    );

    // Offset register: latches the offset of each update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ofs_q <= '0;
        else if (step)
            ofs_q <= ofs_now;
    end

    // Output adder: integer part plus sign-extended latched offset.
    always_comb begin
        div_ratio = {1'b0, n_int} + {{EXT_W{ofs_q[OFS_W-1]}}, ofs_q};
    end

    // R2: last-stage residue offered on an update stays below F
    p_last_residue_r2: assert property (@(posedge clk) disable iff (!rst_n)
        chain[NUM_STAGES] < f_mod);

    // R6: without a strobe the offset seen at the output holds
    p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> (RAT_W'(div_ratio - {1'b0, n_int}) ==
                   $past(RAT_W'(div_ratio - {1'b0, n_int}))));

    // R7: after a reset edge the output equals the integer part
    p_reset_to_n_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (div_ratio == {1'b0, n_int}));

    // R5: ratio never falls below one when N is at least four
    p_ratio_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (n_int >= NI_W'(4)) |-> (div_ratio >= RAT_W'(1)));
endmodule

// File: tb/tb_mash_div_modulator.sv
// Self-checking bench: reference model of the cascade, directed corners and
// seeded random configurations.
module tb_mash_div_modulator;
    localparam int ACC_W = 12;
    localparam int NI_W  = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             step = 1'b0;
    logic [NI_W-1:0]  n_int = 8'd4;
    logic [ACC_W-1:0] k_frac = '0;
    logic [ACC_W-1:0] f_mod = 12'd1;
    logic [NI_W:0]    div_ratio;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    // Reference model state
    int ms [3];
    int pc2, pc3a, pc3b;
    int held_d;
    int cur_k, cur_f, cur_n;

    mash_div_modulator #(.ACC_W(ACC_W), .NI_W(NI_W)) dut (
        .clk(clk), .rst_n(rst_n), .step(step), .n_int(n_int),
        .k_frac(k_frac), .f_mod(f_mod), .div_ratio(div_ratio)
    );

    always #4 clk = ~clk;   // 125 MHz

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual cycle %0d expected < 150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks = n_checks + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 3; i++) ms[i] = 0;
        pc2 = 0; pc3a = 0; pc3b = 0; held_d = 0;
    endtask

    // R1 / R3 reference: modulo accumulators and carry differencing.
    task automatic model_adv(output int d);
        int in_v, s;
        int c [3];
        in_v = cur_k;
        for (int i = 0; i < 3; i++) begin
            s = ms[i] + in_v;
            c[i] = (s >= cur_f) ? 1 : 0;
            ms[i] = (c[i] == 1) ? s - cur_f : s;
            in_v = ms[i];
        end
        d = c[0] + c[1] - pc2 + c[2] - 2 * pc3a + pc3b;
        pc3b = pc3a; pc3a = c[2]; pc2 = c[1];
    endtask

    function automatic int ofs_seen();
        return int'(div_ratio) - int'(n_int);
    endfunction

    // Apply a configuration inside a reset pulse; R7 checked afterwards.
    task automatic do_reset(input int n, input int k, input int f);
        @(negedge clk);
        rst_n = 1'b0;
        n_int = NI_W'(n); k_frac = ACC_W'(k); f_mod = ACC_W'(f);
        cur_n = n; cur_k = k; cur_f = f;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_clear();
        @(negedge clk);
        check(int'(div_ratio) == n, "R7 reset output", int'(div_ratio), n);
    endtask

    // One update; output sampled at the following falling edge.
    task automatic do_step(output int d);
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
        model_adv(d);
        held_d = d;
        check(ofs_seen() == d, "R1 R2 R3 offset", ofs_seen(), d);
        check(ofs_seen() >= -3 && ofs_seen() <= 4, "R4 range", ofs_seen(), d);
        check(int'(div_ratio) == cur_n + d, "R5 ratio", int'(div_ratio), cur_n + d);
    endtask

    // Run a configuration and check F-long window sums (R8).
    task automatic run_cfg(input int n, input int k, input int f, input int steps);
        int d, win, cnt;
        do_reset(n, k, f);
        win = 0; cnt = 0;
        for (int t = 0; t < steps; t++) begin
            do_step(d);
            win = win + ofs_seen();
            cnt = cnt + 1;
            if (k == 0)
                check(ofs_seen() == 0, "R8 zero K", ofs_seen(), 0);
            if (cnt == f) begin
                check(win >= k - 3 && win <= k + 3, "R8 window sum", win, k);
                win = 0; cnt = 0;
            end
        end
    endtask

    // R6 idle hold, then R5 immediate effect of a new N.
    task automatic idle_and_retune(input int new_n);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(ofs_seen() == held_d, "R6 idle hold", ofs_seen(), held_d);
        end
        n_int = NI_W'(new_n);
        cur_n = new_n;
        #1;
        check(int'(div_ratio) == new_n + held_d, "R5 new N", int'(div_ratio), new_n + held_d);
    endtask

    initial begin
        int d, f, k, n;
        void'($urandom(32'd20240611));
        model_clear();
        cur_n = 4; cur_k = 0; cur_f = 1;

        // Directed corners
        run_cfg(4, 0, 1000, 60);          // R8 K = 0
        run_cfg(17, 4, 1000, 2000);        // small fraction
        idle_and_retune(20);
        for (int t = 0; t < 50; t++) do_step(d);
        run_cfg(17, 996, 1000, 2000);      // large fraction, reset from busy state
        idle_and_retune(30);
        run_cfg(255, 4094, 4095, 300);     // R2 K = F-1, largest N
        run_cfg(4, 0, 1, 20);              // F = 1
        run_cfg(4, 1, 2, 40);              // smallest nontrivial modulus

        // Seeded random configurations
        for (int r = 0; r < 8; r++) begin
            f = 2 + int'($urandom % 500);
            k = int'($urandom % f);
            n = 4 + int'($urandom % 252);
            run_cfg(n, k, f, 2 * f + 10);
            idle_and_retune(4 + int'($urandom % 252));
        end

        summary();
        $finish;
    end
endmodule